// File: doc/BRIEF.md
# ADC Power-Mode Control Sequencer

This block is the control state machine that sits between the serial port of a sampling ADC and its power domains. It watches the serial data line while the chip select is low. The first logic 1 clocked in on a rising serial-clock edge is taken as a start bit, and the remainder of an 8-bit control byte follows it. The two least significant bits of that byte choose one of four modes. Two of them are clock modes (internal or external). The other two are software power-down modes (fast or full).

The control byte that asks for power-down is the same byte that launches a conversion. The sequencer runs that one conversion in the last recorded clock mode and waits for the converter's done pulse. Only after that pulse does it drop into the requested low-power state. In either software power-down state the serial receiver keeps running, so the next start bit wakes the converter. The wake-up enables the power domains and counts a parameterised settling delay. The delay is short when the reference stayed up (fast) and long when it did not (full). The ready flag stays low until that count has run out. A hard shutdown input overrides everything and forces full power-down.

States: `ST_FULL_PD` (everything off), `ST_FAST_PD` (reference only), `ST_WAKE` (domains on, settling count running), `ST_ON` (ready, waiting for a byte), `ST_CONVERT` (conversion in flight). Transitions: start bit moves `ST_FULL_PD`/`ST_FAST_PD` to `ST_WAKE`. Count expiry moves `ST_WAKE` to `ST_ON`. A complete pending byte moves `ST_ON` to `ST_CONVERT` and pulses the launch output. The done pulse moves `ST_CONVERT` to `ST_FULL_PD`, `ST_FAST_PD` or `ST_ON` according to the byte's mode code. Hard shutdown moves any state to `ST_FULL_PD`.

Top module: `pmseq_top`

## Requirements
- R1: After reset the block is in full power-down: ref_en, core_en and ready are 0, and clk_ext is 1 (external clock recorded).
- R2: While cs_n is low, zeros sampled on rising sclk edges before the first 1 are ignored. The first 1 is the start bit. A start bit seen in either power-down state raises core_en and ref_en.
- R3: The control byte is 8 bits, sent MSB first, with bit 7 the start bit. Bits [1:0] select the mode: 00 full power-down, 01 fast power-down, 10 internal clock (clk_ext=0), 11 external clock (clk_ext=1). clk_ext changes only in the cycle that a conversion with a clock code is launched.
- R4: conv_go is a one-cycle pulse issued once per complete control byte, and only while ready is 1.
- R5: A byte with a power-down code keeps ready at 1 until conv_done arrives. Only then does the block power down. clk_ext is left unchanged.
- R6: A byte whose bit 1 is 1 leaves the block ready after conv_done.
- R7: In fast power-down, ref_en=1 with core_en=0 and ready=0. In full power-down, all three are 0.
- R8: ready rises exactly FAST_WAKE_CYC+1 cycles after core_en rises when waking from fast power-down, and exactly FULL_WAKE_CYC+1 cycles after when waking from full power-down. It never rises earlier.
- R9: When hard_off is 1, ref_en, core_en and ready are 0 in the following cycle, even if conv_done arrives in the same cycle. Start bits and bytes received while hard_off is 1 have no effect on power or clk_ext.
- R10: Raising cs_n before a byte is complete discards it: no conv_go and no mode change. The next byte is framed from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, sampled on clk, rising edge used |
| din | input | 1 | Serial data in |
| hard_off | input | 1 | Hard shutdown, forces full power-down |
| conv_done | input | 1 | One-cycle pulse from the converter at conversion end |
| ref_en | output | 1 | Reference domain enable |
| core_en | output | 1 | Converter core domain enable |
| ready | output | 1 | Settling complete, conversions allowed |
| conv_go | output | 1 | One-cycle conversion launch pulse |
| clk_ext | output | 1 | Recorded clock mode: 1 external, 0 internal |

## Verification
Hard shutdown and conversion completion can land on the same clock edge while a conversion is in flight. The done pulse would otherwise route the machine to ready or to a software power-down. The bench provokes this by driving hard_off and conv_done together in one cycle, after a launch with an internal-clock byte. It judges the result from the enables one cycle later: everything must be off. It also checks that a later wake takes the long settling count, which proves the machine landed in full rather than fast power-down. A second coincidence, byte completion during the settling count, is judged by a launch pulse that must wait until ready is high.

// File: rtl/pmseq_pkg.sv
package pmseq_pkg;

    typedef enum logic [2:0] {
        ST_FULL_PD = 3'd0,
        ST_FAST_PD = 3'd1,
        ST_WAKE    = 3'd2,
        ST_ON      = 3'd3,
        ST_CONVERT = 3'd4
    } pm_state_t;

    typedef enum logic [1:0] {
        MODE_FULL_PD = 2'b00,
        MODE_FAST_PD = 2'b01,
        MODE_CLK_INT = 2'b10,
        MODE_CLK_EXT = 2'b11
    } pm_mode_t;

endpackage

// File: rtl/pmseq_rx.sv
module pmseq_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              start_p,
    output logic              byte_p,
    output logic [BYTE_W-2:0] payload
);
    localparam int PAY_W = BYTE_W - 1;
    localparam int CW    = $clog2(PAY_W + 1);

    logic          sclk_q;
    logic          busy;
    logic [CW-1:0] cnt;
    logic          rise;

    assign rise = sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            busy    <= 1'b0;
            cnt     <= '0;
            payload <= '0;
            start_p <= 1'b0;
            byte_p  <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            start_p <= 1'b0;
            byte_p  <= 1'b0;
            if (cs_n) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (rise) begin
                if (!busy) begin
                    if (din) begin
                        busy    <= 1'b1;
                        cnt     <= '0;
                        start_p <= 1'b1;
                    end
                end else begin
                    payload <= {payload[PAY_W-2:0], din};
                    if (cnt == CW'(PAY_W - 1)) begin
                        busy   <= 1'b0;
                        cnt    <= '0;
                        byte_p <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pmseq_timer.sv
module pmseq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pmseq_decode.sv
module pmseq_decode
    import pmseq_pkg::*;
(
    input  logic [1:0] code,
    output pm_mode_t   mode,
    output logic       stay_on,
    output logic       ext_clk
);
    always_comb begin
        mode    = pm_mode_t'(code);
        stay_on = code[1];
        ext_clk = (mode == MODE_CLK_EXT);
    end
endmodule

// File: rtl/pmseq_top.sv
module pmseq_top
    import pmseq_pkg::*;
#(
    parameter int BYTE_W        = 8,
    parameter int FAST_WAKE_CYC = 1000,
    parameter int FULL_WAKE_CYC = 60000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    input  logic hard_off,
    input  logic conv_done,
    output logic ref_en,
    output logic core_en,
    output logic ready,
    output logic conv_go,
    output logic clk_ext
);
    localparam int MAX_WAKE = (FULL_WAKE_CYC > FAST_WAKE_CYC) ? FULL_WAKE_CYC : FAST_WAKE_CYC;
    localparam int TW       = $clog2(MAX_WAKE + 1);

    pm_state_t         state, nxt;
    logic              start_p, byte_p;
    logic [BYTE_W-2:0] payload;
    logic              pend_v;
    logic [1:0]        pend_code, cur_code;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    pm_mode_t          cur_mode, pend_mode;
    logic              cur_stay, pend_stay, cur_ext, pend_ext;
    logic              go;

    pmseq_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .start_p(start_p), .byte_p(byte_p), .payload(payload)
    );

    pmseq_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_exp)
    );

    pmseq_decode u_dec_cur (
        .code(cur_code), .mode(cur_mode), .stay_on(cur_stay), .ext_clk(cur_ext)
    );

    pmseq_decode u_dec_pend (
        .code(pend_code), .mode(pend_mode), .stay_on(pend_stay), .ext_clk(pend_ext)
    );

    // next-state and transition strobes
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        go       = 1'b0;
        if (hard_off) begin
            nxt = ST_FULL_PD;
        end else begin
            unique case (state)
                ST_FULL_PD: if (start_p) begin
                    nxt      = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(FULL_WAKE_CYC);
                end
                ST_FAST_PD: if (start_p) begin
                    nxt      = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(FAST_WAKE_CYC);
                end
                ST_WAKE: if (tmr_exp) nxt = ST_ON;
                ST_ON: if (pend_v) begin
                    nxt = ST_CONVERT;
                    go  = 1'b1;
                end
                ST_CONVERT: if (conv_done) begin
                    if (cur_stay)                    nxt = ST_ON;
                    else if (cur_mode == MODE_FAST_PD) nxt = ST_FAST_PD;
                    else                             nxt = ST_FULL_PD;
                end
                default: nxt = ST_FULL_PD;
            endcase
        end
    end

    // state register and mode bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FULL_PD;
            pend_v    <= 1'b0;
            pend_code <= 2'b00;
            cur_code  <= 2'b00;
            clk_ext   <= 1'b1;
        end else begin
            state <= nxt;
            if (hard_off) begin
                pend_v <= 1'b0;
            end else if (byte_p) begin
                pend_v    <= 1'b1;
                pend_code <= payload[1:0];
            end else if (go) begin
                pend_v <= 1'b0;
            end
            if (go) begin
                cur_code <= pend_code;
                if (pend_stay) clk_ext <= pend_ext;
            end
        end
    end

    // outputs
    always_comb begin
        ref_en  = (state != ST_FULL_PD);
        core_en = (state == ST_WAKE) || (state == ST_ON) || (state == ST_CONVERT);
        ready   = (state == ST_ON) || (state == ST_CONVERT);
        conv_go = go;
    end
endmodule

// File: rtl/pmseq_chk.sv
module pmseq_chk #(
    parameter int FAST_WAKE_CYC = 1000,
    parameter int FULL_WAKE_CYC = 60000
) (
    input logic clk,
    input logic rst_n,
    input logic hard_off,
    input logic ref_en,
    input logic core_en,
    input logic ready,
    input logic conv_go,
    input logic clk_ext
);
    localparam int SAT = FULL_WAKE_CYC + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] core_cnt, ref_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_cnt <= '0;
            ref_cnt  <= '0;
        end else begin
            if (!core_en)                  core_cnt <= '0;
            else if (core_cnt != CW'(SAT)) core_cnt <= core_cnt + 1'b1;
            if (!ref_en)                   ref_cnt <= '0;
            else if (ref_cnt != CW'(SAT))  ref_cnt <= ref_cnt + 1'b1;
        end
    end

    AST_READY_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (core_cnt >= CW'(FAST_WAKE_CYC))); // R8
    AST_READY_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (ref_cnt >= CW'(FULL_WAKE_CYC))); // R8
    AST_HARD_OFF_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        hard_off |=> (!ref_en && !core_en && !ready)); // R9
    AST_GO_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |-> ready); // R4
    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_go |=> !conv_go); // R4
    AST_CLK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_go |=> $stable(clk_ext)); // R3
    AST_CORE_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> ref_en); // R7
endmodule

bind pmseq_top pmseq_chk #(
    .FAST_WAKE_CYC(FAST_WAKE_CYC),
    .FULL_WAKE_CYC(FULL_WAKE_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .hard_off(hard_off), .ref_en(ref_en),
    .core_en(core_en), .ready(ready), .conv_go(conv_go), .clk_ext(clk_ext)
);

// File: tb/sim_pmseq_top.sv
`timescale 1ns/1ps
module sim_pmseq_top;
    localparam int FAST = 20;
    localparam int FULL = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, hard_off = 1'b0, conv_done = 1'b0;
    logic ref_en, core_en, ready, conv_go, clk_ext;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, go_cnt = 0, t_core = -1, t_ready = -1;
    logic core_prev = 1'b0, ready_prev = 1'b0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    pmseq_top #(.BYTE_W(8), .FAST_WAKE_CYC(FAST), .FULL_WAKE_CYC(FULL)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .hard_off(hard_off), .conv_done(conv_done), .ref_en(ref_en),
        .core_en(core_en), .ready(ready), .conv_go(conv_go), .clk_ext(clk_ext)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (core_en && !core_prev)  t_core  <= cyc;
        if (ready && !ready_prev)   t_ready <= cyc;
        if (conv_go)                go_cnt  <= go_cnt + 1;
        core_prev  <= core_en;
        ready_prev <= ready;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk) din = b;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) cs_n = 1'b0;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_go(input int g0, input string req);
        for (int i = 0; i < 400 && go_cnt == g0; i++) @(negedge clk);
        chk(go_cnt == g0 + 1, req, go_cnt, g0 + 1);
    endtask

    task automatic pulse_done();
        repeat (5) @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk) conv_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(ref_en == 1'b0,  "R1 ref_en",  ref_en,  0);
        chk(core_en == 1'b0, "R1 core_en", core_en, 0);
        chk(ready == 1'b0,   "R1 ready",   ready,   0);
        chk(clk_ext == 1'b1, "R1 clk_ext", clk_ext, 1);
    endtask

    task automatic t_zeros();
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        @(negedge clk) cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(core_en == 1'b0 && ref_en == 1'b0, "R2 zeros ignored", core_en, 0);
    endtask

    task automatic t_ext_from_full();
        int g0 = go_cnt;
        t_core = -1; t_ready = -1;
        send_byte(8'h83);
        wait_go(g0, "R4 launch after full wake");
        chk(t_core >= 0, "R2 start bit wakes", t_core, 0);
        chk(t_ready - t_core == FULL + 1, "R8 full wake delay", t_ready - t_core, FULL + 1);
        chk(clk_ext == 1'b1, "R3 code 11 external", clk_ext, 1);
        pulse_done();
        chk(ready == 1'b1, "R6 stays ready after ext", ready, 1);
    endtask

    task automatic t_internal();
        int g0 = go_cnt;
        send_byte(8'h82);
        wait_go(g0, "R4 launch internal");
        @(negedge clk);
        chk(clk_ext == 1'b0, "R3 code 10 internal", clk_ext, 0);
        pulse_done();
        chk(ready == 1'b1, "R6 stays ready after int", ready, 1);
    endtask

    task automatic t_abort();
        int g0 = go_cnt;
        logic ce = clk_ext;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        @(negedge clk) cs_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(go_cnt == g0, "R10 no launch on aborted byte", go_cnt, g0);
        chk(clk_ext == ce, "R10 mode kept on abort", clk_ext, ce);
        send_byte(8'h83);
        wait_go(g0, "R10 fresh framing after abort");
        @(negedge clk);
        chk(clk_ext == 1'b1, "R10 next byte decoded", clk_ext, 1);
        pulse_done();
    endtask

    task automatic t_fast_pd();
        int g0 = go_cnt;
        logic ce = clk_ext;
        send_byte(8'h81);
        wait_go(g0, "R4 launch fast pd byte");
        repeat (3) @(negedge clk);
        chk(ready == 1'b1, "R5 ready held until done", ready, 1);
        pulse_done();
        chk(ref_en == 1'b1 && core_en == 1'b0 && ready == 1'b0, "R7 fast power-down",
            {ref_en, core_en, ready}, 3'b100);
        chk(clk_ext == ce, "R5 clock mode unchanged", clk_ext, ce);
    endtask

    task automatic t_fast_wake();
        int g0 = go_cnt;
        t_core = -1; t_ready = -1;
        send_byte(8'h82);
        wait_go(g0, "R2 wake from fast");
        chk(t_ready - t_core == FAST + 1, "R8 fast wake delay", t_ready - t_core, FAST + 1);
        pulse_done();
    endtask

    task automatic t_full_pd();
        int g0 = go_cnt;
        send_byte(8'h80);
        wait_go(g0, "R4 launch full pd byte");
        pulse_done();
        chk(ref_en == 1'b0 && core_en == 1'b0 && ready == 1'b0, "R7 full power-down",
            {ref_en, core_en, ready}, 0);
    endtask

    task automatic t_hard();
        int g0 = go_cnt;
        send_byte(8'h82);
        wait_go(g0, "R4 launch before shutdown");
        repeat (3) @(negedge clk);
        hard_off = 1'b1;
        conv_done = 1'b1;
        @(negedge clk) conv_done = 1'b0;
        chk(ref_en == 1'b0 && core_en == 1'b0 && ready == 1'b0, "R9 shutdown beats done",
            {ref_en, core_en, ready}, 0);
        g0 = go_cnt;
        send_byte(8'h83);
        chk(core_en == 1'b0 && go_cnt == g0, "R9 start bit ignored in shutdown", core_en, 0);
        chk(clk_ext == 1'b0, "R9 byte ignored in shutdown", clk_ext, 0);
        @(negedge clk) hard_off = 1'b0;
        repeat (10) @(negedge clk);
        chk(core_en == 1'b0, "R9 stays off after release", core_en, 0);
        t_core = -1; t_ready = -1;
        send_byte(8'h83);
        wait_go(g0, "R9 wake after release");
        chk(t_ready - t_core == FULL + 1, "R8 full delay after shutdown", t_ready - t_core, FULL + 1);
        pulse_done();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_zeros();
        t_ext_from_full();
        t_internal();
        t_abort();
        t_fast_pd();
        t_fast_wake();
        t_full_pd();
        t_hard();
        report();
    end
endmodule